// File: doc/BRIEF.md
# General-purpose I/O port with pin event interrupts

This block is one 32-pin general-purpose I/O port on a simple memory-mapped register bus. Software drives output levels and per-pin output enables, and reads back the pin levels after they pass through a clock-domain synchroniser. Every configuration register can be written whole, or changed bit by bit through set, clear and toggle aliases. With these aliases a driver can change one pin without a read-modify-write sequence.

Each pin can be routed into event detection. There it is treated as a rising-edge, falling-edge, high-level or low-level source, chosen by two per-pin bits. Detected events land in sticky status bits. Software can only remove them by writing ones to the clear alias of the status register. A per-pin enable selects which pending bits drive the interrupt outputs. With the split option, the lower half of the pins drives `irq_o` and the upper half drives `irq_hi_o`. Without it, `irq_o` covers all pins.

The address decodes as follows. Bits [6:4] select the register. Bits [3:2] select the access kind. Bits [1:0] and every bit above bit 6 must be zero. A write to any other address is ignored, and a read from one returns zero.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero, `pin_o` and `pin_oe` are all zero (every pin an input), and both interrupt outputs are low.
- R2: The register is selected by address bits [6:4] as follows: 0 output data, 1 output enable, 2 input data, 3 event route, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Address bits [3:2] select the access kind: 0 direct write, 1 set, 2 clear, 3 toggle. A direct write replaces the register, and a read at any of the four access addresses of a register returns its value in the same cycle.
- R3: A set write ORs the data into the register, a clear write removes the bits written as one, and a toggle write inverts the bits written as one. Bits written as zero keep their value.
- R4: `pin_o` equals the output-data register and `pin_oe` equals the output-enable register, where 1 makes the pin an output.
- R5: The input-data register shows `pin_i` through a two-stage synchroniser, so a pin change is visible after the second rising clock edge. Writes to the input-data register, of any access kind, have no effect.
- R6: With level select 0 a pin is edge sensitive. Polarity 1 detects rising edges and polarity 0 detects falling edges. The status bit becomes 1 at the third rising clock edge after the pin change, and the opposite edge sets nothing.
- R7: With level select 1 a pin is level sensitive. Polarity 1 means high is active and polarity 0 means low is active. If the status bit is cleared while the pin is still active, the bit reads 0 right after the clearing write and 1 again one clock later.
- R8: A pin whose route bit is 0 never sets its status bit, whatever its activity.
- R9: Status bits drop only through the clear alias of the status register. Direct, set and toggle writes to the status register leave it unchanged, and a clear write of all ones empties it.
- R10: An interrupt output is high while any pin it covers has both its status bit and its interrupt-enable bit at 1. The enable masks the output but not the status bit.
- R11: With `SPLIT_IRQ`=1 (the default), `irq_o` covers pins 0 to 15 and `irq_hi_o` covers pins 16 to 31. With `SPLIT_IRQ`=0, `irq_o` covers all pins and `irq_hi_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 together with bus_en |
| bus_addr | input | ADDR_W | Byte address of register and access kind |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data of the addressed register |
| pin_i | input | NPINS | Asynchronous pin levels |
| pin_o | output | NPINS | Output levels for the pads |
| pin_oe | output | NPINS | Output enables for the pads |
| irq_o | output | 1 | Interrupt for all pins, or the lower half when split |
| irq_hi_o | output | 1 | Interrupt for the upper half when split, else 0 |

## Verification
The hardest case to reach is a level-sensitive pin that is still active at the moment software clears its status bit. The bench has to observe the short zero right after the clearing write and then the bit set again one clock later. To get there, the stimulus holds the pin active, issues the clear write, and reads status on the two negative edges that follow. A second hard case is proving that direct, set and toggle writes cannot move status. For that, the bench first builds real pending events on two pins. It then cuts their routing so that no new event can mask an unwanted change, and only then applies each write kind.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [2:0] {
        RG_DOUT  = 3'd0,
        RG_DOE   = 3'd1,
        RG_DIN   = 3'd2,
        RG_ROUTE = 3'd3,
        RG_IEN   = 3'd4,
        RG_LVL   = 3'd5,
        RG_POL   = 3'd6,
        RG_STAT  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        AL_WRITE = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_TGL   = 2'd3
    } alias_e;

    typedef struct packed {
        reg_sel_e sel;
        alias_e   al;
    } bus_dec_t;

    // indices of the plain configuration registers
    localparam int CI_DOUT  = 0;
    localparam int CI_DOE   = 1;
    localparam int CI_ROUTE = 2;
    localparam int CI_IEN   = 3;
    localparam int CI_LVL   = 4;
    localparam int CI_POL   = 5;
    localparam int NCFG     = 6;

    function automatic bus_dec_t decode_addr(input logic [4:0] a);
        bus_dec_t d;
        d.sel = reg_sel_e'(a[4:2]);
        d.al  = alias_e'(a[1:0]);
        return d;
    endfunction

    function automatic reg_sel_e cfg_slot(input int idx);
        case (idx)
            CI_DOUT:  return RG_DOUT;
            CI_DOE:   return RG_DOE;
            CI_ROUTE: return RG_ROUTE;
            CI_IEN:   return RG_IEN;
            CI_LVL:   return RG_LVL;
            default:  return RG_POL;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] route,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= smp;
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic lvl_hit;
        logic edg_hit;
        assign lvl_hit = ~(smp[p] ^ pol[p]);
        assign edg_hit = pol[p] ? (smp[p] & ~prev_q[p]) : (~smp[p] & prev_q[p]);
        assign evt[p]  = route[p] & (lvl[p] ? lvl_hit : edg_hit);
    end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  alias_e       al,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_n;

    always_comb begin
        q_n = q;
        if (wr_en) begin
            unique case (al)
                AL_WRITE: q_n = wdata;
                AL_SET:   q_n = q | wdata;
                AL_CLR:   q_n = q & ~wdata;
                AL_TGL:   q_n = q ^ wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_n;
    end

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && al == AL_WRITE) |=> (q == $past(wdata)));
    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && al == AL_SET) |=> (q == ($past(q) | $past(wdata))));
    // R3
    clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && al == AL_CLR) |=> (q == ($past(q) & ~$past(wdata))));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int W     = 32,
    parameter bit SPLIT = 1'b1
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] en,
    output logic         irq_lo,
    output logic         irq_hi
);
    localparam int HALF = W / 2;

    logic [W-1:0] act;
    assign act = stat & en;

    if (SPLIT) begin : g_split
        assign irq_lo = |act[HALF-1:0];
        assign irq_hi = |act[W-1:HALF];
    end else begin : g_flat
        assign irq_lo = |act;
        assign irq_hi = 1'b0;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit SPLIT_IRQ   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_o,
    output logic              irq_hi_o
);
    bus_dec_t         dec;
    logic             addr_ok;
    logic             wr_act;
    logic [NPINS-1:0] cfg_q [NCFG];
    logic [NPINS-1:0] din;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] stat_clr;

    assign dec     = decode_addr(bus_addr[6:2]);
    assign addr_ok = ~|{bus_addr[ADDR_W-1:7], bus_addr[1:0]};
    assign wr_act  = bus_en & bus_we & addr_ok;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        gpio_cfg_reg #(.W(NPINS)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_act && (dec.sel == cfg_slot(g))),
            .al    (dec.al),
            .wdata (bus_wdata),
            .q     (cfg_q[g])
        );
    end

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (din)
    );

    gpio_evt_detect #(.W(NPINS)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .smp   (din),
        .route (cfg_q[CI_ROUTE]),
        .lvl   (cfg_q[CI_LVL]),
        .pol   (cfg_q[CI_POL]),
        .evt   (evt)
    );

    // clear write wins over a same-cycle event on that bit
    assign stat_clr = (wr_act && dec.sel == RG_STAT && dec.al == AL_CLR) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q | evt) & ~stat_clr;
    end

    gpio_irq_merge #(.W(NPINS), .SPLIT(SPLIT_IRQ)) u_irq (
        .stat   (stat_q),
        .en     (cfg_q[CI_IEN]),
        .irq_lo (irq_o),
        .irq_hi (irq_hi_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (dec.sel)
                RG_DOUT:  bus_rdata = cfg_q[CI_DOUT];
                RG_DOE:   bus_rdata = cfg_q[CI_DOE];
                RG_DIN:   bus_rdata = din;
                RG_ROUTE: bus_rdata = cfg_q[CI_ROUTE];
                RG_IEN:   bus_rdata = cfg_q[CI_IEN];
                RG_LVL:   bus_rdata = cfg_q[CI_LVL];
                RG_POL:   bus_rdata = cfg_q[CI_POL];
                RG_STAT:  bus_rdata = stat_q;
            endcase
        end
    end

    assign pin_o  = cfg_q[CI_DOUT];
    assign pin_oe = cfg_q[CI_DOE];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_q == '0 && pin_oe == '0 && pin_o == '0 && !irq_o && !irq_hi_o));
    // R8
    route_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~$past(cfg_q[CI_ROUTE])) == '0));
    // R9
    stat_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_q) & ~stat_q)) |-> $past(|stat_clr));
    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o || irq_hi_o) |-> (|(stat_q & cfg_q[CI_IEN])));
    // R10
    irq_present_chk: assert property (@(posedge clk) disable iff (rst)
        (|(stat_q & cfg_q[CI_IEN])) |-> (irq_o || irq_hi_o));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    localparam int R_DOUT = 0, R_DOE = 1, R_DIN = 2, R_ROUTE = 3;
    localparam int R_IEN = 4, R_LVL = 5, R_POL = 6, R_STAT = 7;
    localparam int A_WR = 0, A_SET = 1, A_CLR = 2, A_TGL = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, pin_i, pin_o, pin_oe;
    logic        irq_o, irq_hi_o;
    logic [31:0] f_rdata, f_pin_o, f_pin_oe;
    logic        f_irq, f_irq_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe(pin_oe), .irq_o(irq_o), .irq_hi_o(irq_hi_o)
    );

    gpio_port #(.SPLIT_IRQ(1'b0)) i_gpio_port_flat (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(f_rdata), .pin_i(pin_i), .pin_o(f_pin_o),
        .pin_oe(f_pin_oe), .irq_o(f_irq), .irq_hi_o(f_irq_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int r, input int al, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1;
        bus_addr = 8'(r * 16 + al * 4);
        bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int r, input int al, output logic [31:0] d);
        bus_we = 1'b0;
        bus_addr = 8'(r * 16 + al * 4);
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 8; r++) begin
            rd(r, A_WR, v);
            chk($sformatf("R1 register %0d after reset", r), v, 32'h0);
        end
        chk("R1 pin_o after reset", pin_o, 32'h0);
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        chk("R1 irq outputs after reset", {30'h0, irq_hi_o, irq_o}, 32'h0);
    endtask

    task automatic t_direct();
        wr(R_DOUT, A_WR, 32'hA5A5_0F0F);
        rd(R_DOUT, A_WR, v);
        chk("R2 direct write output data", v, 32'hA5A5_0F0F);
        chk("R4 pin_o follows output data", pin_o, 32'hA5A5_0F0F);
        wr(R_DOE, A_WR, 32'hFFFF_0000);
        rd(R_DOE, A_TGL, v);
        chk("R2 read through toggle address", v, 32'hFFFF_0000);
        chk("R4 pin_oe follows output enable", pin_oe, 32'hFFFF_0000);
    endtask

    task automatic t_alias();
        wr(R_DOUT, A_SET, 32'h0000_F0F0);
        rd(R_DOUT, A_WR, v);
        chk("R3 set alias", v, 32'hA5A5_FFFF);
        wr(R_DOUT, A_CLR, 32'hA500_000F);
        rd(R_DOUT, A_SET, v);
        chk("R3 clear alias", v, 32'h00A5_FFF0);
        wr(R_DOUT, A_TGL, 32'hFFFF_0000);
        rd(R_DOUT, A_CLR, v);
        chk("R3 toggle alias", v, 32'hFF5A_FFF0);
        wr(R_DOE, A_CLR, 32'hFFFF_FFFF);
        chk("R3 R4 clear all enables", pin_oe, 32'h0);
        wr(R_DOUT, A_WR, 32'h0);
    endtask

    task automatic t_din();
        pin_i = 32'h1234_5678;
        cyc(1);
        rd(R_DIN, A_WR, v);
        chk("R5 input data before second edge", v, 32'h0);
        cyc(1);
        rd(R_DIN, A_WR, v);
        chk("R5 input data after second edge", v, 32'h1234_5678);
        wr(R_DIN, A_WR, 32'h0);
        wr(R_DIN, A_CLR, 32'hFFFF_FFFF);
        wr(R_DIN, A_TGL, 32'hFFFF_FFFF);
        rd(R_DIN, A_WR, v);
        chk("R5 writes to input data ignored", v, 32'h1234_5678);
        pin_i = 32'h0;
        cyc(3);
    endtask

    task automatic t_edge();
        wr(R_ROUTE, A_SET, 32'h8);
        wr(R_IEN, A_SET, 32'h8);
        wr(R_POL, A_SET, 32'h8);
        pin_i[3] = 1'b1;
        cyc(2);
        rd(R_STAT, A_WR, v);
        chk("R6 rising edge not yet latched", v, 32'h0);
        cyc(1);
        rd(R_STAT, A_WR, v);
        chk("R6 rising edge latched on third edge", v, 32'h8);
        chk("R10 irq_o for enabled pin 3", {31'h0, irq_o}, 32'h1);
        wr(R_STAT, A_CLR, 32'h8);
        rd(R_STAT, A_WR, v);
        chk("R9 clear of edge status", v, 32'h0);
        chk("R10 irq_o low after clear", {31'h0, irq_o}, 32'h0);
        pin_i[3] = 1'b0;
        cyc(4);
        rd(R_STAT, A_WR, v);
        chk("R6 falling edge ignored in rising mode", v, 32'h0);
        wr(R_POL, A_CLR, 32'h8);
        pin_i[3] = 1'b1;
        cyc(4);
        rd(R_STAT, A_WR, v);
        chk("R6 rising edge ignored in falling mode", v, 32'h0);
        pin_i[3] = 1'b0;
        cyc(3);
        rd(R_STAT, A_WR, v);
        chk("R6 falling edge latched", v, 32'h8);
        wr(R_ROUTE, A_CLR, 32'h8);
        wr(R_IEN, A_CLR, 32'h8);
        wr(R_STAT, A_CLR, 32'h8);
    endtask

    task automatic t_level();
        wr(R_LVL, A_SET, 32'h20);
        wr(R_POL, A_SET, 32'h20);
        wr(R_ROUTE, A_SET, 32'h20);
        rd(R_STAT, A_WR, v);
        chk("R7 inactive high level sets nothing", v, 32'h0);
        pin_i[5] = 1'b1;
        cyc(3);
        rd(R_STAT, A_WR, v);
        chk("R7 high level latched", v, 32'h20);
        wr(R_STAT, A_CLR, 32'h20);
        rd(R_STAT, A_WR, v);
        chk("R7 status zero right after clear", v, 32'h0);
        cyc(1);
        rd(R_STAT, A_WR, v);
        chk("R7 status set again one clock later", v, 32'h20);
        pin_i[5] = 1'b0;
        cyc(3);
        wr(R_STAT, A_CLR, 32'h20);
        cyc(1);
        rd(R_STAT, A_WR, v);
        chk("R7 stays clear once level inactive", v, 32'h0);
        wr(R_POL, A_CLR, 32'h20);
        cyc(1);
        rd(R_STAT, A_WR, v);
        chk("R7 low level latched", v, 32'h20);
        wr(R_ROUTE, A_CLR, 32'h20);
        wr(R_STAT, A_CLR, 32'h20);
        wr(R_LVL, A_CLR, 32'h20);
        rd(R_STAT, A_WR, v);
        chk("R7 level pin cleaned up", v, 32'h0);
    endtask

    task automatic t_route();
        wr(R_POL, A_SET, 32'h80);
        wr(R_IEN, A_SET, 32'h80);
        pin_i[7] = 1'b1;
        cyc(4);
        pin_i[7] = 1'b0;
        cyc(4);
        rd(R_STAT, A_WR, v);
        chk("R8 unrouted pin sets no status", v, 32'h0);
        chk("R8 unrouted pin raises no irq", {31'h0, irq_o}, 32'h0);
        wr(R_IEN, A_CLR, 32'h80);
        wr(R_POL, A_CLR, 32'h80);
    endtask

    task automatic t_stat();
        wr(R_ROUTE, A_SET, 32'h600);
        pin_i[10:9] = 2'b11;
        cyc(4);
        pin_i[10:9] = 2'b00;
        cyc(3);
        wr(R_ROUTE, A_CLR, 32'h600);
        rd(R_STAT, A_WR, v);
        chk("R9 two pending falling events", v, 32'h600);
        wr(R_STAT, A_WR, 32'h0);
        rd(R_STAT, A_WR, v);
        chk("R9 direct write leaves status", v, 32'h600);
        wr(R_STAT, A_TGL, 32'h600);
        rd(R_STAT, A_WR, v);
        chk("R9 toggle write leaves status", v, 32'h600);
        wr(R_STAT, A_SET, 32'hFFFF_FFFF);
        rd(R_STAT, A_WR, v);
        chk("R9 set write leaves status", v, 32'h600);
        wr(R_STAT, A_CLR, 32'hFFFF_FFFF);
        rd(R_STAT, A_WR, v);
        chk("R9 clear of all ones empties status", v, 32'h0);
    endtask

    task automatic t_mask();
        wr(R_ROUTE, A_SET, 32'h1000);
        pin_i[12] = 1'b1;
        cyc(4);
        pin_i[12] = 1'b0;
        cyc(3);
        rd(R_STAT, A_WR, v);
        chk("R10 masked pin still latches status", v, 32'h1000);
        chk("R10 masked pin keeps irq_o low", {31'h0, irq_o}, 32'h0);
        wr(R_IEN, A_SET, 32'h1000);
        chk("R10 enabling raises irq_o", {31'h0, irq_o}, 32'h1);
        wr(R_IEN, A_CLR, 32'h1000);
        chk("R10 disabling drops irq_o", {31'h0, irq_o}, 32'h0);
        rd(R_STAT, A_WR, v);
        chk("R10 mask leaves status", v, 32'h1000);
        wr(R_ROUTE, A_CLR, 32'h1000);
        wr(R_STAT, A_CLR, 32'h1000);
    endtask

    task automatic t_split();
        wr(R_ROUTE, A_SET, 32'h0010_0000);
        wr(R_IEN, A_SET, 32'h0010_0000);
        pin_i[20] = 1'b1;
        cyc(4);
        pin_i[20] = 1'b0;
        cyc(3);
        rd(R_STAT, A_WR, v);
        chk("R11 pin 20 status", v, 32'h0010_0000);
        chk("R11 split: pin 20 on irq_hi_o only", {30'h0, irq_hi_o, irq_o}, 32'h2);
        chk("R11 flat: pin 20 on irq_o, irq_hi_o low", {30'h0, f_irq_hi, f_irq}, 32'h1);
        wr(R_STAT, A_CLR, 32'hFFFF_FFFF);
        chk("R11 split outputs low after clear", {30'h0, irq_hi_o, irq_o}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_direct();
        t_alias();
        t_din();
        t_edge();
        t_level();
        t_route();
        t_stat();
        t_mask();
        t_split();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule